// File: doc/BRIEF.md
# Alarm Relay Port Controller

This block is a byte-level I2C slave that drives four active-low alarm outputs: power, critical, major and minor. It also reports back the state of the major and minor alarms. The host reaches it at 7-bit address 0x20. The address byte is 0x40 for a write and 0x41 for a read. Every data byte written updates one 8-bit port register. A read returns the live pin levels and the state of the alarm latches.

The power and critical outputs copy their register bits directly. The major and minor outputs are latched. A latch is set only when the written bit goes from 1 to 0. It is released by writing 1, or by its own active-high clear input, so an operator can silence the relay without the host. Software can see that such a clear happened through the two sense bits. A low level on the fan-fail input forces the power alarm on, whatever the register holds.

The slave is a state machine with these states:
- `ST_IDLE`: waits for a START.
- `ST_ADDR`: shifts in the address byte.
- `ST_ADDR_ACK`: drives the address acknowledge.
- `ST_WR_DATA` / `ST_WR_ACK`: receives each data byte and acknowledges it.
- `ST_RD_DATA` / `ST_RD_ACK`: shifts out the read byte and samples the host's acknowledge.

Its transitions are:
- START from any state → `ST_ADDR`.
- STOP from any state → `ST_IDLE`.
- After eight address bits: → `ST_ADDR_ACK` on an address match, or → `ST_IDLE` on a mismatch.
- From the acknowledge slot: → `ST_WR_DATA` or → `ST_RD_DATA`, depending on the direction bit.
- After each written byte: → `ST_WR_ACK`, then back → `ST_WR_DATA`.
- After each read byte: → `ST_RD_ACK`, then → `ST_RD_DATA` on a host ACK, or → `ST_IDLE` on a NACK.

Top module: `alarm_relay_ctrl`

## Requirements
- R1: The slave acknowledges only the address bytes 0x40 (write) and 0x41 (read). For any other address it leaves SDA released and ignores the bytes that follow, so the outputs do not change.
- R2: After power-up reset all four alarm outputs are high (off), both latches are off, and a read returns 0xFF.
- R3: `power_alarm_n` follows written bit 0 and `critical_alarm_n` follows written bit 1. A value of 0 means on (low) and 1 means off (high).
- R4: While `fan_fail_n` is low, `power_alarm_n` is low, whatever register bit 0 holds.
- R5: The major latch is set only by a written bit 2 of 0 when the previously written bit 2 was 1. A written 1 clears it. `major_alarm_n` is low exactly while the latch is set.
- R6: The minor latch behaves like the major latch, using written bit 3 and `minor_alarm_n`.
- R7: An active-high level on `major_clr` or `minor_clr` clears the matching latch within three clocks and takes priority over a set. A later write of 0, when the previous written value of that bit was already 0, does not set the latch again.
- R8: The read byte carries the pin levels of power, critical, major and minor in bits 0 to 3. Bit 4 is 0 when the major latch is on and bit 5 is 0 when the minor latch is on. Bits 6 and 7 are always 1. Written values of bits 4 to 7 have no effect.
- R9: Each data byte that follows an accepted write address is acknowledged. The bytes are applied in the order they were sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the bus |
| rst_n | input | 1 | Active-low power-up reset |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Bus data level (wired-AND line) |
| sda_pull | output | 1 | High to pull SDA low (open-drain drive) |
| fan_fail_n | input | 1 | Active-low fan failure; forces the power alarm on |
| major_clr | input | 1 | Active-high external clear of the major latch |
| minor_clr | input | 1 | Active-high external clear of the minor latch |
| power_alarm_n | output | 1 | Power alarm output, low = on |
| critical_alarm_n | output | 1 | Critical alarm output, low = on |
| major_alarm_n | output | 1 | Major alarm output, low = on |
| minor_alarm_n | output | 1 | Minor alarm output, low = on |

## Verification
The assertions check four things on every clock:
- The fan-fail override holds.
- The critical output moves only in the cycle after a data-write strobe.
- Each latch falls only after a strobe that carried a 0 in its bit.
- A clear level held for three clocks leaves the matching output off.

The bench scenarios cover what needs whole bus transactions:
- Address filtering and acknowledge behaviour.
- The 1-to-0 edge rule across successive writes.
- A repeated 0 after an external clear not setting the latch again.
- Multi-byte writes.
- The exact bit layout of the read byte.

// File: rtl/alarm_relay_pkg.sv
package alarm_relay_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK
    } slv_state_t;
endpackage

// File: rtl/alarm_bus_sync.sv
module alarm_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_in};
            sda_sh <= {sda_sh[STAGES-2:0], sda_in};
            scl_d  <= scl_sh[STAGES-1];
            sda_d  <= sda_sh[STAGES-1];
        end
    end

    always_comb begin
        scl_s     = scl_sh[STAGES-1];
        sda_s     = sda_sh[STAGES-1];
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        bus_start = scl_s & scl_d & sda_d & ~sda_s;
        bus_stop  = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/alarm_slave_fsm.sv
module alarm_slave_fsm
    import alarm_relay_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              sda_pull,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_byte
);
    slv_state_t        state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              rd_dir;
    logic              host_nack;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            shreg     <= '0;
            rd_dir    <= 1'b0;
            host_nack <= 1'b1;
        end else if (bus_start) begin
            state   <= ST_ADDR;
            bit_cnt <= '0;
        end else if (bus_stop) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_ADDR: begin
                    if (scl_rise) begin
                        shreg   <= {shreg[BYTE_W-2:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (scl_fall && bit_cnt == CNT_W'(BYTE_W)) begin
                        rd_dir <= shreg[0];
                        state  <= (shreg[BYTE_W-1:1] == SLAVE_ADDR) ? ST_ADDR_ACK : ST_IDLE;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (rd_dir) begin
                            shreg <= rd_byte;
                            state <= ST_RD_DATA;
                        end else begin
                            state <= ST_WR_DATA;
                        end
                    end
                end
                ST_WR_DATA: begin
                    if (scl_rise) begin
                        shreg   <= {shreg[BYTE_W-2:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (scl_fall && bit_cnt == CNT_W'(BYTE_W)) begin
                        state <= ST_WR_ACK;
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        state   <= ST_WR_DATA;
                    end
                end
                ST_RD_DATA: begin
                    if (scl_fall) begin
                        if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                            state <= ST_RD_ACK;
                        end else begin
                            shreg   <= {shreg[BYTE_W-2:0], 1'b1};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        host_nack <= sda_s;
                    end else if (scl_fall) begin
                        bit_cnt <= '0;
                        if (!host_nack) begin
                            shreg <= rd_byte;
                            state <= ST_RD_DATA;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        sda_pull = 1'b0;
        wr_stb   = 1'b0;
        wr_byte  = shreg;
        unique case (state)
            ST_ADDR_ACK, ST_WR_ACK: sda_pull = 1'b1;
            ST_RD_DATA:             sda_pull = ~shreg[BYTE_W-1];
            ST_WR_DATA:             wr_stb = scl_fall && (bit_cnt == CNT_W'(BYTE_W))
                                             && !bus_start && !bus_stop;
            default: ;
        endcase
    end
endmodule

// File: rtl/alarm_port_reg.sv
module alarm_port_reg
    import alarm_relay_pkg::*;
#(
    parameter int CLR_SYNC = 2,
    parameter int N_LATCH  = 2,
    parameter int LATCH_LO = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic [N_LATCH-1:0] ext_clr,
    output logic              pwr_bit,
    output logic              crit_bit,
    output logic [N_LATCH-1:0] latch_on
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_bit  <= 1'b1;
            crit_bit <= 1'b1;
        end else if (wr_stb) begin
            pwr_bit  <= wr_byte[0];
            crit_bit <= wr_byte[1];
        end
    end

    for (genvar k = 0; k < N_LATCH; k++) begin : g_latch
        logic [CLR_SYNC-1:0] clr_sh;
        logic                last_wr;
        logic                wbit;

        assign wbit = wr_byte[LATCH_LO + k];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                clr_sh      <= '0;
                last_wr     <= 1'b1;
                latch_on[k] <= 1'b0;
            end else begin
                clr_sh <= {clr_sh[CLR_SYNC-2:0], ext_clr[k]};
                if (wr_stb) last_wr <= wbit;
                if (clr_sh[CLR_SYNC-1])
                    latch_on[k] <= 1'b0;
                else if (wr_stb && wbit)
                    latch_on[k] <= 1'b0;
                else if (wr_stb && !wbit && last_wr)
                    latch_on[k] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/alarm_relay_ctrl.sv
module alarm_relay_ctrl
    import alarm_relay_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h20,
    parameter int          SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_pull,
    input  logic fan_fail_n,
    input  logic major_clr,
    input  logic minor_clr,
    output logic power_alarm_n,
    output logic critical_alarm_n,
    output logic major_alarm_n,
    output logic minor_alarm_n
);
    logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic wr_stb;
    logic [BYTE_W-1:0] wr_byte, rd_byte;
    logic pwr_bit, crit_bit;
    logic [1:0] latch_on;

    alarm_bus_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop)
    );

    alarm_slave_fsm #(.SLAVE_ADDR(SLAVE_ADDR)) fsm_i (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop),
        .rd_byte(rd_byte), .sda_pull(sda_pull), .wr_stb(wr_stb), .wr_byte(wr_byte)
    );

    alarm_port_reg #(.CLR_SYNC(SYNC_STAGES)) port_i (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_byte(wr_byte),
        .ext_clr({minor_clr, major_clr}), .pwr_bit(pwr_bit),
        .crit_bit(crit_bit), .latch_on(latch_on)
    );

    always_comb begin
        power_alarm_n    = pwr_bit & fan_fail_n;
        critical_alarm_n = crit_bit;
        major_alarm_n    = ~latch_on[0];
        minor_alarm_n    = ~latch_on[1];
        rd_byte = {2'b11, minor_alarm_n, major_alarm_n,
                   minor_alarm_n, major_alarm_n, critical_alarm_n, power_alarm_n};
    end
endmodule

// File: rtl/alarm_relay_checker.sv
module alarm_relay_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       fan_fail_n,
    input logic       major_clr,
    input logic       minor_clr,
    input logic       power_alarm_n,
    input logic       critical_alarm_n,
    input logic       major_alarm_n,
    input logic       minor_alarm_n,
    input logic       wr_stb,
    input logic [7:0] wr_byte
);
    logic [2:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 1'b1;
    end

    assert_fan_override_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !fan_fail_n |-> !power_alarm_n);

    assert_crit_moves_on_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 3'd0 && !$stable(critical_alarm_n)) |-> $past(wr_stb));

    assert_major_set_by_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 3'd0 && $fell(major_alarm_n)) |-> ($past(wr_stb) && !$past(wr_byte[2])));

    assert_minor_set_by_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 3'd0 && $fell(minor_alarm_n)) |-> ($past(wr_stb) && !$past(wr_byte[3])));

    assert_major_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd4 && $past(major_clr, 1) && $past(major_clr, 2) && $past(major_clr, 3))
        |-> major_alarm_n);

    assert_minor_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd4 && $past(minor_clr, 1) && $past(minor_clr, 2) && $past(minor_clr, 3))
        |-> minor_alarm_n);
endmodule

bind alarm_relay_ctrl alarm_relay_checker chk_i (
    .clk(clk), .rst_n(rst_n), .fan_fail_n(fan_fail_n), .major_clr(major_clr),
    .minor_clr(minor_clr), .power_alarm_n(power_alarm_n),
    .critical_alarm_n(critical_alarm_n), .major_alarm_n(major_alarm_n),
    .minor_alarm_n(minor_alarm_n), .wr_stb(wr_stb), .wr_byte(wr_byte)
);

// File: tb/alarm_relay_ctrl_tb.sv
module alarm_relay_ctrl_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam time HALF = CLK_PERIOD * 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_pull;
    logic fan_fail_n = 1'b1;
    logic major_clr = 1'b0;
    logic minor_clr = 1'b0;
    logic power_alarm_n, critical_alarm_n, major_alarm_n, minor_alarm_n;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // reference model state
    bit m_pwr = 1, m_crit = 1, m_majwr = 1, m_minwr = 1, m_maj_on = 0, m_min_on = 0;

    assign sda_line = sda_m & ~sda_pull;

    always #(CLK_PERIOD / 2) clk = ~clk;

    alarm_relay_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line), .sda_pull(sda_pull),
        .fan_fail_n(fan_fail_n), .major_clr(major_clr), .minor_clr(minor_clr),
        .power_alarm_n(power_alarm_n), .critical_alarm_n(critical_alarm_n),
        .major_alarm_n(major_alarm_n), .minor_alarm_n(minor_alarm_n)
    );

    function automatic logic [3:0] exp_pins();
        return {~m_min_on, ~m_maj_on, m_crit, m_pwr & fan_fail_n};
    endfunction

    function automatic logic [7:0] exp_read();
        logic [3:0] p = exp_pins();
        return {2'b11, p[3], p[2], p};
    endfunction

    task automatic model_write(input logic [7:0] d);
        m_pwr = d[0];
        m_crit = d[1];
        if (d[2]) m_maj_on = 0; else if (m_majwr) m_maj_on = 1;
        m_majwr = d[2];
        if (d[3]) m_min_on = 0; else if (m_minwr) m_min_on = 1;
        m_minwr = d[3];
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1; scl = 1; #HALF;
        sda_m = 0; #HALF;
        scl = 0; #HALF;
    endtask

    task automatic bus_stop();
        sda_m = 0; #HALF;
        scl = 1; #HALF;
        sda_m = 1; #HALF;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic nack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; #HALF;
            scl = 1; #HALF;
            scl = 0;
        end
        sda_m = 1; #HALF;
        scl = 1; #(HALF / 2);
        nack = sda_line; #(HALF / 2);
        scl = 0;
    endtask

    task automatic recv_byte(input logic nack_bit, output logic [7:0] b);
        sda_m = 1;
        for (int i = 7; i >= 0; i--) begin
            #HALF; scl = 1; #(HALF / 2);
            b[i] = sda_line; #(HALF / 2);
            scl = 0;
        end
        sda_m = nack_bit; #HALF;
        scl = 1; #HALF;
        scl = 0;
    endtask

    task automatic do_write(input logic [7:0] addr, input logic [7:0] d, output logic na, output logic nd);
        bus_start();
        send_byte(addr, na);
        send_byte(d, nd);
        bus_stop();
    endtask

    task automatic do_read(output logic [7:0] b, output logic na);
        bus_start();
        send_byte(8'h41, na);
        recv_byte(1'b1, b);
        bus_stop();
    endtask

    task automatic write_check(input logic [7:0] d, input string req);
        logic na, nd;
        do_write(8'h40, d, na, nd);
        model_write(d);
        check({req, " ack"}, {6'd0, na, nd}, 8'h00);
        check({req, " pins"}, {4'd0, minor_alarm_n, major_alarm_n, critical_alarm_n, power_alarm_n},
              {4'd0, exp_pins()});
    endtask

    task automatic read_check(input string req);
        logic [7:0] b;
        logic na;
        do_read(b, na);
        check({req, " read"}, b, exp_read());
    endtask

    task automatic pulse_clr(input bit maj, input bit min);
        major_clr = maj; minor_clr = min;
        repeat (10) @(negedge clk);
        major_clr = 0; minor_clr = 0;
        repeat (10) @(negedge clk);
        if (maj) m_maj_on = 0;
        if (min) m_min_on = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic na, nd;
        logic [7:0] b;
        int unsigned seed_val;
        seed_val = $urandom(32'd4711);
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (5) @(negedge clk);

        // R2: reset state
        check("R2 pins", {4'd0, minor_alarm_n, major_alarm_n, critical_alarm_n, power_alarm_n}, 8'h0F);
        read_check("R2");

        // R3 power/critical follow
        write_check(8'hFE, "R3");
        write_check(8'hFD, "R3");
        write_check(8'hFF, "R3");

        // R1 wrong address: NACK and no effect
        do_write(8'h42, 8'h00, na, nd);
        check("R1 nack", {7'd0, na}, 8'h01);
        check("R1 no effect", {4'd0, minor_alarm_n, major_alarm_n, critical_alarm_n, power_alarm_n},
              {4'd0, exp_pins()});
        do_write(8'h44, 8'h00, na, nd);
        check("R1 other nack", {7'd0, na}, 8'h01);

        // R4 fan override
        fan_fail_n = 0; repeat (2) @(negedge clk);
        check("R4 override", {7'd0, power_alarm_n}, 8'h00);
        read_check("R4");
        fan_fail_n = 1; repeat (2) @(negedge clk);
        check("R4 release", {7'd0, power_alarm_n}, 8'h01);

        // R5 major edge set, write-1 clear
        write_check(8'hFB, "R5 set");
        write_check(8'hFB, "R5 hold");
        write_check(8'hFF, "R5 clear");
        // R6 minor
        write_check(8'hF7, "R6 set");
        read_check("R8 minor sense");
        write_check(8'hFF, "R6 clear");

        // R7 external clear then repeated zero does not re-set
        write_check(8'hF3, "R7 both set");
        pulse_clr(1, 0);
        check("R7 major cleared", {6'd0, minor_alarm_n, major_alarm_n}, 8'h01);
        read_check("R7 sense");
        write_check(8'hF3, "R7 repeated zero");
        pulse_clr(0, 1);
        check("R7 minor cleared", {6'd0, minor_alarm_n, major_alarm_n}, 8'h03);
        write_check(8'hFF, "R7 rearm");
        write_check(8'hF3, "R7 reset again");

        // R8 written upper bits ignored
        write_check(8'h0F, "R8 upper zero");
        read_check("R8 upper");

        // R9 multi-byte write, applied in order
        bus_start();
        send_byte(8'h40, na);
        send_byte(8'hFF, nd);
        check("R9 first ack", {6'd0, na, nd}, 8'h00);
        model_write(8'hFF);
        send_byte(8'hF9, nd);
        check("R9 second ack", {7'd0, nd}, 8'h00);
        model_write(8'hF9);
        bus_stop();
        check("R9 pins", {4'd0, minor_alarm_n, major_alarm_n, critical_alarm_n, power_alarm_n},
              {4'd0, exp_pins()});

        // random mix (R3 R5 R6 R7 R8)
        for (int it = 0; it < 30; it++) begin
            logic [7:0] d;
            int unsigned r;
            d = 8'($urandom);
            r = $urandom % 8;
            fan_fail_n = (r != 0);
            write_check(d, "R5 R6 random");
            if (r == 1) pulse_clr(1, 0);
            if (r == 2) pulse_clr(0, 1);
            if (r == 3) pulse_clr(1, 1);
            read_check("R8 random");
        end
        fan_fail_n = 1;

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule